// File: doc/BRIEF.md
# Exception Entry Unit

This block turns one exception request into everything a processor core must write when it enters a handler. It works out the address the handler will later return to, decides the branch-delay flag, places the exception code and the coprocessor-error field into a cause word, chooses the address to jump to, and pulses the status updates the entry needs. Three entry paths are handled: ordinary exceptions, error-level entries and debug entries. Each path saves its return address into its own register.

The core presents the faulting PC, a flag saying whether that instruction sat in a branch delay slot, the present exception-level and boot-vector bits, a kind code and, for coprocessor faults, the coprocessor number. One cycle later the unit raises a one-cycle entry strobe. Its registered outputs then hold the new return address, cause word and vector. The same strobe tells the core to drop any pending delayed branch.

Top module: `exc_entry_unit`

## Requirements
- R1: After a synchronous active-low reset every output is zero: entry strobe, status pulses, branch-clear pulse, vector, cause word and all three return-address registers.
- R2: The return address is the PC minus 4 when the faulting instruction is in a delay slot, and the PC itself otherwise. Kinds 0 to 4 write it to the normal register `epc_o`, kind 5 to `err_epc_o` and kind 6 to `dbg_epc_o`. The other two registers keep their values.
- R3: On every entry path, bit 31 of the cause word is the branch-delay flag. It becomes 1 for a delay-slot entry while the exception level is clear, keeps its previous value for a delay-slot entry while the exception level is set, and becomes 0 for an entry outside a delay slot.
- R4: Bits 6:2 of the cause word carry the exception code. Kind 0 (interrupt) writes 0, kind 1 (coprocessor unusable) writes 11, kind 2 (overflow) writes 12, kind 3 (system call) writes 8 and kind 4 (breakpoint) writes 9. Kinds 5 and 6 leave the code as it was.
- R5: Bits 29:28 of the cause word hold the coprocessor number. Only kind 1 overwrites them, with `cop_num_i`. Every other kind leaves them as they were. Bits 30, 27:7 and 1:0 read zero.
- R6: A normal entry (kinds 0 to 4) selects vector 0xBFC00200 when the boot-vector bit is set and 0x80000180 when it is clear, and pulses `set_exl_o`.
- R7: An error entry (kind 5) selects vector 0xBFC00000 and pulses both `set_erl_o` and `set_bev_o`.
- R8: A debug entry (kind 6) selects vector 0xBFC00480 and pulses `set_dbg_o`. At most one of `set_exl_o`, `set_erl_o` and `set_dbg_o` is high in any cycle.
- R9: An accepted request (valid high, kind 0 to 6) raises `entry_o` and `clr_bpend_o` for exactly the next cycle, and requests in consecutive cycles each produce an entry. Kind 7 is reserved: it produces no entry and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid_i | input | 1 | Exception request this cycle |
| exc_kind_i | input | 3 | Kind code (0 intr, 1 cop unusable, 2 overflow, 3 syscall, 4 break, 5 error, 6 debug, 7 reserved) |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| in_dslot_i | input | 1 | Faulting instruction is in a branch delay slot |
| st_exl_i | input | 1 | Exception level currently set |
| st_bev_i | input | 1 | Boot-vector bit currently set |
| cop_num_i | input | 2 | Coprocessor number for a coprocessor-unusable fault |
| entry_o | output | 1 | One-cycle entry strobe |
| vector_o | output | 32 | Handler address of the latest entry |
| epc_o | output | 32 | Return address, normal path |
| err_epc_o | output | 32 | Return address, error path |
| dbg_epc_o | output | 32 | Return address, debug path |
| cause_o | output | 32 | Cause word (delay flag, coprocessor field, code) |
| set_exl_o | output | 1 | Pulse: set exception level |
| set_erl_o | output | 1 | Pulse: set error level |
| set_bev_o | output | 1 | Pulse: set boot-vector bit |
| set_dbg_o | output | 1 | Pulse: enter debug mode |
| clr_bpend_o | output | 1 | Pulse: drop pending delayed branch |

## Verification
Two functions meet in one cycle here: the delay-slot rewind of the return address and the rule that freezes the branch-delay flag when the exception level is already set. Both act on the same entry. The bench sends delay-slot entries with the exception level set, just after entries that left the flag at 1 and at 0. It expects the rewound address in the path's register, while bit 31 keeps whatever the earlier entry left. A coprocessor fault at PC zero in a delay slot also checks that the address wraps while the coprocessor field is rewritten in the same update.

// File: rtl/exc_entry_pkg.sv
// Package: exc_entry_pkg
// Shared kind and path encodings and cause-word field positions for the
// exception entry unit. Assumes a 3-bit kind code and a 5-bit cause code.
package exc_entry_pkg;

    typedef enum logic [2:0] {
        K_INTR = 3'd0,
        K_COPU = 3'd1,
        K_OVF  = 3'd2,
        K_SYS  = 3'd3,
        K_BRK  = 3'd4,
        K_ERR  = 3'd5,
        K_DBG  = 3'd6,
        K_RSVD = 3'd7
    } exc_kind_e;

    typedef enum logic [1:0] {
        P_NONE = 2'd0,
        P_NORM = 2'd1,
        P_ERR  = 2'd2,
        P_DBG  = 2'd3
    } exc_path_e;

    localparam int CODE_W  = 5;
    localparam int CE_W    = 2;
    localparam int BD_BIT  = 31;
    localparam int CE_LSB  = 28;
    localparam int CODE_LSB = 2;

    localparam logic [CODE_W-1:0] C_INTR = 5'd0;
    localparam logic [CODE_W-1:0] C_COPU = 5'd11;
    localparam logic [CODE_W-1:0] C_OVF  = 5'd12;
    localparam logic [CODE_W-1:0] C_SYS  = 5'd8;
    localparam logic [CODE_W-1:0] C_BRK  = 5'd9;

endpackage

// File: rtl/exc_path_decode.sv
// Module: exc_path_decode
// Maps a kind code to its entry path, the cause code it writes, whether
// the coprocessor field is rewritten, and the handler vector.
// Assumes: pure combinational; the vector of a normal entry depends on
// the boot-vector bit, error and debug entries have fixed vectors.
module exc_path_decode
    import exc_entry_pkg::*;
#(
    parameter int               AW       = 32,
    parameter logic [AW-1:0]    VEC_BOOT = 32'hBFC0_0200,
    parameter logic [AW-1:0]    VEC_RUN  = 32'h8000_0180,
    parameter logic [AW-1:0]    VEC_ERR  = 32'hBFC0_0000,
    parameter logic [AW-1:0]    VEC_DBG  = 32'hBFC0_0480
) (
    input  logic [2:0]          kind_i,
    input  logic                bev_i,
    output exc_path_e           path_o,
    output logic [CODE_W-1:0]   code_o,
    output logic                code_wr_o,
    output logic                ce_wr_o,
    output logic [AW-1:0]       vector_o
);

    // Decode kind into path, code and field-write enables
    always_comb begin
        path_o    = P_NORM;
        code_o    = C_INTR;
        code_wr_o = 1'b1;
        ce_wr_o   = 1'b0;
        unique case (exc_kind_e'(kind_i))
            K_INTR: code_o = C_INTR;
            K_COPU: begin
                code_o  = C_COPU;
                ce_wr_o = 1'b1;
            end
            K_OVF:  code_o = C_OVF;
            K_SYS:  code_o = C_SYS;
            K_BRK:  code_o = C_BRK;
            K_ERR: begin
                path_o    = P_ERR;
                code_wr_o = 1'b0;
            end
            K_DBG: begin
                path_o    = P_DBG;
                code_wr_o = 1'b0;
            end
            default: begin
                path_o    = P_NONE;
                code_wr_o = 1'b0;
            end
        endcase
    end

    // Select the handler address for the chosen path
    always_comb begin
        unique case (path_o)
            P_ERR:   vector_o = VEC_ERR;
            P_DBG:   vector_o = VEC_DBG;
            default: vector_o = bev_i ? VEC_BOOT : VEC_RUN;
        endcase
    end

endmodule

// File: rtl/exc_bd_retaddr.sv
// Module: exc_bd_retaddr
// Computes the return address and the next branch-delay flag for an entry.
// Assumes: instructions are INSN_BYTES wide; the flag is only raised when
// the exception level is clear and is kept when it is already set.
module exc_bd_retaddr #(
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [AW-1:0] pc_i,
    input  logic          dslot_i,
    input  logic          exl_i,
    input  logic          bd_cur_i,
    output logic [AW-1:0] ret_o,
    output logic          bd_next_o
);

    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    // Rewind to the branch when the fault sits in its delay slot
    always_comb ret_o = dslot_i ? (pc_i - STEP) : pc_i;

    // Delay flag: raise outside exception level, hold inside, clear otherwise
    always_comb begin
        if (!dslot_i)
            bd_next_o = 1'b0;
        else if (exl_i)
            bd_next_o = bd_cur_i;
        else
            bd_next_o = 1'b1;
    end

endmodule

// File: rtl/exc_entry_unit.sv
// Module: exc_entry_unit
// Registers the outcome of one exception entry per cycle: the return
// address into the register of its path, the cause word fields, the
// vector and one-cycle status pulses. Assumes the core supplies the live
// exception-level and boot-vector bits and applies the pulses itself.
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exc_valid_i,
    input  logic [2:0]    exc_kind_i,
    input  logic [31:0]   exc_pc_i,
    input  logic          in_dslot_i,
    input  logic          st_exl_i,
    input  logic          st_bev_i,
    input  logic [1:0]    cop_num_i,
    output logic          entry_o,
    output logic [31:0]   vector_o,
    output logic [31:0]   epc_o,
    output logic [31:0]   err_epc_o,
    output logic [31:0]   dbg_epc_o,
    output logic [31:0]   cause_o,
    output logic          set_exl_o,
    output logic          set_erl_o,
    output logic          set_bev_o,
    output logic          set_dbg_o,
    output logic          clr_bpend_o
);

    localparam int PAD_HI = BD_BIT - (CE_LSB + CE_W);
    localparam int PAD_MD = CE_LSB - (CODE_LSB + CODE_W);

    exc_path_e          path;
    logic [CODE_W-1:0]  code_new;
    logic               code_wr;
    logic               ce_wr;
    logic [AW-1:0]      vec_new;
    logic [AW-1:0]      ret_new;
    logic               bd_new;
    logic               accept;

    logic               bd_q;
    logic [CE_W-1:0]    ce_q;
    logic [CODE_W-1:0]  code_q;

    exc_path_decode #(.AW(AW)) u_decode (
        .kind_i    (exc_kind_i),
        .bev_i     (st_bev_i),
        .path_o    (path),
        .code_o    (code_new),
        .code_wr_o (code_wr),
        .ce_wr_o   (ce_wr),
        .vector_o  (vec_new)
    );

    exc_bd_retaddr #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_retaddr (
        .pc_i      (exc_pc_i),
        .dslot_i   (in_dslot_i),
        .exl_i     (st_exl_i),
        .bd_cur_i  (bd_q),
        .ret_o     (ret_new),
        .bd_next_o (bd_new)
    );

    // A request is taken when valid and its kind maps to a path
    always_comb accept = exc_valid_i && (path != P_NONE);

    // Strobes and status pulses last exactly one cycle after a taken request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_o     <= 1'b0;
            clr_bpend_o <= 1'b0;
            set_exl_o   <= 1'b0;
            set_erl_o   <= 1'b0;
            set_bev_o   <= 1'b0;
            set_dbg_o   <= 1'b0;
        end else begin
            entry_o     <= accept;
            clr_bpend_o <= accept;
            set_exl_o   <= accept && (path == P_NORM);
            set_erl_o   <= accept && (path == P_ERR);
            set_bev_o   <= accept && (path == P_ERR);
            set_dbg_o   <= accept && (path == P_DBG);
        end
    end

    // Cause fields and vector change only on a taken request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bd_q     <= 1'b0;
            ce_q     <= '0;
            code_q   <= '0;
            vector_o <= '0;
        end else if (accept) begin
            bd_q     <= bd_new;
            vector_o <= vec_new;
            if (code_wr) code_q <= code_new;
            if (ce_wr)   ce_q   <= cop_num_i;
        end
    end

    // Return address lands only in the register of the taken path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o     <= '0;
            err_epc_o <= '0;
            dbg_epc_o <= '0;
        end else if (accept) begin
            unique case (path)
                P_ERR:   err_epc_o <= ret_new;
                P_DBG:   dbg_epc_o <= ret_new;
                default: epc_o     <= ret_new;
            endcase
        end
    end

    // Assemble the cause word from its held fields
    always_comb cause_o = {bd_q, {PAD_HI{1'b0}}, ce_q, {PAD_MD{1'b0}},
                           code_q, {CODE_LSB{1'b0}}};

endmodule

// File: rtl/exc_entry_chk.sv
// Module: exc_entry_chk
// Checker for exc_entry_unit, attached by bind. Watches ports only.
module exc_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        exc_valid_i,
    input logic [2:0]  exc_kind_i,
    input logic [31:0] exc_pc_i,
    input logic        in_dslot_i,
    input logic        st_exl_i,
    input logic        entry_o,
    input logic [31:0] epc_o,
    input logic [31:0] cause_o,
    input logic        set_exl_o,
    input logic        set_erl_o,
    input logic        set_bev_o,
    input logic        set_dbg_o,
    input logic        clr_bpend_o
);

    logic take;
    always_comb take = exc_valid_i && (exc_kind_i != 3'd7);

    // R9: a taken request yields an entry strobe next cycle
    a_r9_entry_follows: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (entry_o && clr_bpend_o));

    // R9: no request (or a reserved one) yields no strobe next cycle
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> (!entry_o && !clr_bpend_o));

    // R3: an entry outside a delay slot clears the delay flag
    a_r3_bd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_dslot_i) |=> !cause_o[31]);

    // R3: a delay-slot entry at exception level keeps the delay flag
    a_r3_bd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_dslot_i && st_exl_i) |=> (cause_o[31] == $past(cause_o[31])));

    // R2: normal entries store the rewound or plain PC
    a_r2_epc_value: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && (exc_kind_i <= 3'd4)) |=>
        (epc_o == ($past(in_dslot_i) ? ($past(exc_pc_i) - 32'd4) : $past(exc_pc_i))));

    // R5: kinds other than coprocessor-unusable keep the coprocessor field
    a_r5_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && (exc_kind_i != 3'd1)) |=> $stable(cause_o[29:28]));

    // R7: an error-level entry always comes with the boot-vector pulse
    a_r7_erl_with_bev: assert property (@(posedge clk) disable iff (!rst_n)
        set_erl_o |-> set_bev_o);

    // R8: the three level pulses never overlap
    a_r8_paths_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_exl_o, set_erl_o, set_dbg_o}));

endmodule

bind exc_entry_unit exc_entry_chk u_exc_entry_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_valid_i (exc_valid_i),
    .exc_kind_i  (exc_kind_i),
    .exc_pc_i    (exc_pc_i),
    .in_dslot_i  (in_dslot_i),
    .st_exl_i    (st_exl_i),
    .entry_o     (entry_o),
    .epc_o       (epc_o),
    .cause_o     (cause_o),
    .set_exl_o   (set_exl_o),
    .set_erl_o   (set_erl_o),
    .set_bev_o   (set_bev_o),
    .set_dbg_o   (set_dbg_o),
    .clr_bpend_o (clr_bpend_o)
);

// File: tb/exc_entry_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard. The driver task updates a reference model built from
// the requirements and queues the expected result; the monitor pops one
// item per entry strobe and compares every output.
module exc_entry_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [2:0]  exc_kind_i = '0;
    logic [31:0] exc_pc_i = '0;
    logic        in_dslot_i = 1'b0;
    logic        st_exl_i = 1'b0;
    logic        st_bev_i = 1'b0;
    logic [1:0]  cop_num_i = '0;
    logic        entry_o;
    logic [31:0] vector_o, epc_o, err_epc_o, dbg_epc_o, cause_o;
    logic        set_exl_o, set_erl_o, set_bev_o, set_dbg_o, clr_bpend_o;

    always #2.5 clk = ~clk;

    exc_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid_i),
        .exc_kind_i(exc_kind_i), .exc_pc_i(exc_pc_i), .in_dslot_i(in_dslot_i),
        .st_exl_i(st_exl_i), .st_bev_i(st_bev_i), .cop_num_i(cop_num_i),
        .entry_o(entry_o), .vector_o(vector_o), .epc_o(epc_o),
        .err_epc_o(err_epc_o), .dbg_epc_o(dbg_epc_o), .cause_o(cause_o),
        .set_exl_o(set_exl_o), .set_erl_o(set_erl_o), .set_bev_o(set_bev_o),
        .set_dbg_o(set_dbg_o), .clr_bpend_o(clr_bpend_o)
    );

    typedef struct packed {
        logic [31:0] vec;
        logic [31:0] cause;
        logic [31:0] epc;
        logic [31:0] eepc;
        logic [31:0] depc;
        logic [3:0]  fl;   // {exl, erl, bev, dbg}
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;

    // reference model state
    logic        m_bd = 1'b0;
    logic [4:0]  m_code = '0;
    logic [1:0]  m_ce = '0;
    logic [31:0] m_epc = '0, m_eepc = '0, m_depc = '0, m_vec = '0;

    function automatic logic [31:0] m_cause();
        return {m_bd, 1'b0, m_ce, 21'd0, m_code, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: update model, queue expectation, present request for one cycle
    task automatic do_exc(input logic [2:0] k, input logic [31:0] pc, input logic ds,
                          input logic exl, input logic bev, input logic [1:0] cop);
        logic [31:0] ret;
        exp_t e;
        @(negedge clk);
        if (k != 3'd7) begin
            ret  = ds ? pc - 32'd4 : pc;
            m_bd = ds ? (exl ? m_bd : 1'b1) : 1'b0;
            case (k)
                3'd5: begin m_eepc = ret; m_vec = 32'hBFC0_0000; e.fl = 4'b0110; end
                3'd6: begin m_depc = ret; m_vec = 32'hBFC0_0480; e.fl = 4'b0001; end
                default: begin
                    m_epc = ret;
                    m_vec = bev ? 32'hBFC0_0200 : 32'h8000_0180;
                    e.fl  = 4'b1000;
                    case (k)
                        3'd0: m_code = 5'd0;
                        3'd1: begin m_code = 5'd11; m_ce = cop; end
                        3'd2: m_code = 5'd12;
                        3'd3: m_code = 5'd8;
                        default: m_code = 5'd9;
                    endcase
                end
            endcase
            e.vec = m_vec; e.cause = m_cause(); e.epc = m_epc;
            e.eepc = m_eepc; e.depc = m_depc;
            exp_q.push_back(e);
        end
        exc_valid_i = 1'b1; exc_kind_i = k; exc_pc_i = pc;
        in_dslot_i = ds; st_exl_i = exl; st_bev_i = bev; cop_num_i = cop;
    endtask

    task automatic idle();
        @(negedge clk);
        exc_valid_i = 1'b0;
    endtask

    // Monitor: each strobe must match the oldest queued expectation
    always @(negedge clk) begin
        if (rst_n && entry_o) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected entry", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R6/R7/R8 vector", vector_o, e.vec);
                chk("R3 delay flag", {31'd0, cause_o[31]}, {31'd0, e.cause[31]});
                chk("R4 code", {27'd0, cause_o[6:2]}, {27'd0, e.cause[6:2]});
                chk("R5 cause word", cause_o, e.cause);
                chk("R2 epc", epc_o, e.epc);
                chk("R2 err_epc", err_epc_o, e.eepc);
                chk("R2 dbg_epc", dbg_epc_o, e.depc);
                chk("R6/R7/R8 status pulses", {28'd0, set_exl_o, set_erl_o, set_bev_o, set_dbg_o},
                    {28'd0, e.fl});
                chk("R9 branch clear", {31'd0, clr_bpend_o}, 32'd1);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 entry", {31'd0, entry_o}, 32'd0);
        chk("R1 pulses", {27'd0, set_exl_o, set_erl_o, set_bev_o, set_dbg_o, clr_bpend_o}, 32'd0);
        chk("R1 vector", vector_o, 32'd0);
        chk("R1 cause", cause_o, 32'd0);
        chk("R1 epcs", epc_o | err_epc_o | dbg_epc_o, 32'd0);

        do_exc(3'd0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 2'd0); idle();   // R6 run vector
        do_exc(3'd1, 32'h0000_2004, 1'b1, 1'b0, 1'b1, 2'd2); idle();   // R3 set, R5, R6 boot
        do_exc(3'd2, 32'h0000_3008, 1'b1, 1'b1, 1'b0, 2'd1); idle();   // R3 hold at 1, R5 keep
        do_exc(3'd3, 32'h0000_4000, 1'b0, 1'b0, 1'b0, 2'd0); idle();   // R3 clear, R4 syscall
        do_exc(3'd4, 32'h0000_4100, 1'b1, 1'b1, 1'b1, 2'd0); idle();   // R3 hold at 0, R4 break
        do_exc(3'd5, 32'h0000_5000, 1'b1, 1'b0, 1'b0, 2'd0); idle();   // R7, R2 error reg
        do_exc(3'd6, 32'h0000_6000, 1'b0, 1'b1, 1'b0, 2'd0); idle();   // R8, R2 debug reg
        do_exc(3'd1, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 2'd3); idle();   // R2 wrap, R5 field 3

        // R9 reserved kind: no entry, nothing changes
        do_exc(3'd7, 32'h0000_7000, 1'b1, 1'b0, 1'b1, 2'd1);
        idle();
        chk("R9 reserved no entry", {31'd0, entry_o}, 32'd0);
        chk("R9 reserved cause kept", cause_o, m_cause());
        chk("R9 reserved epc kept", epc_o, m_epc);
        chk("R9 reserved vector kept", vector_o, m_vec);

        // R9 back-to-back requests, each must produce its own entry
        do_exc(3'd6, 32'h0000_8004, 1'b1, 1'b0, 1'b0, 2'd0);
        do_exc(3'd5, 32'h0000_9000, 1'b0, 1'b0, 1'b0, 2'd0);
        do_exc(3'd2, 32'h0000_A008, 1'b1, 1'b1, 1'b1, 2'd0);
        idle();
        @(negedge clk);
        chk("R9 strobe one cycle", {31'd0, entry_o}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R9 all entries seen", exp_q.size(), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule